// File: doc/BRIEF.md
# Swap-Correlation Mismatch Calibrator for One Pipeline Stage

This block performs the digital half of a background calibration for a single 1-bit or 1.5-bit stage of a pipelined converter whose residue amplifier can exchange its two capacitors. On every conversion it presents a pseudorandom exchange bit to the analog stage. Some conversions later it receives the stage decision digit and the residue code that the back-end stages have digitized. It removes the part of the residue that depends on the exchange bit and the digit, and outputs the cleaned-up code.

The size of that part is not known in advance. The block learns it while the converter runs normally. It correlates each cleaned-up code with the product of the exchange value and the digit, and moves a signed running estimate against that correlation by a power-of-two step. The exchange sequence is balanced, so the converter input averages out of the correlation and only the capacitor error remains. No test signal is needed. Conversions with a zero digit carry no information and leave the estimate alone. The estimate saturates at a programmable bound, and a synchronous clear returns it to zero.

Top module: `capcal_stage`

## Requirements
- R1: While reset is asserted and after its release, `est_o` is 0, `corr_vld_o` is 0, `corr_o` is 0 and `swap_o` equals bit 0 of the seed parameter.
- R2: The exchange bit comes from a Fibonacci LFSR of width LFSR_W, loaded with the seed at reset. For the default width 16 the feedback is the XOR of state bits 15, 13, 12 and 10. On each accepted sample the new state is {state[W-2:0], feedback}. `swap_o` is state bit 0, and 1 means exchange value +1 while 0 means -1.
- R3: A sample accepted on strobe k uses the exchange value that `swap_o` showed during strobe k-LAT. For the first LAT strobes after reset the value used is -1.
- R4: Digit encoding is 2'b01 = +1, 2'b11 = -1 and 2'b00 = 0. The code 2'b10 is never legal. When HALF_BIT is 0 (1-bit stage), 2'b00 is also illegal.
- R5: One clock after an accepted sample, `corr_vld_o` is 1 and `corr_o` = res + s·d·floor(est/2^FRAC_W). Here s is the exchange value used, d is the digit and est is the estimate before that sample's update. `corr_vld_o` is 0 one clock after any cycle without a strobe.
- R6: For a nonzero digit, the next estimate is est − s·d·corr·2^(FRAC_W−STEP_SH), in units of 2^-FRAC_W code LSB. This is a step of 2^-STEP_SH applied to the correlation.
- R7: A sample with digit 0 leaves the estimate unchanged, and its corrected code equals the input residue.
- R8: The estimate is limited to ±EST_LIM and never wraps.
- R9: A clear request sets the estimate to 0 on the next edge and takes priority over a concurrent update. The corrected code of that same sample still uses the old estimate.
- R10: In cycles without a strobe, the LFSR state, the exchange history, the estimate and `corr_o` all hold.
- R11: When the residue contains a term s·d·δ, the estimate converges to −δ·2^FRAC_W to within a few code LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| est_clr_i | input | 1 | Synchronous clear of the estimate |
| smp_vld_i | input | 1 | Strobe: one conversion accepted this cycle |
| digit_i | input | 2 | Stage digit, encoded as in R4 |
| res_i | input | CODE_W | Signed back-end residue code |
| swap_o | output | 1 | Exchange control to the analog stage (1 = +1) |
| corr_o | output | CODE_W+1 | Signed corrected residue code |
| corr_vld_o | output | 1 | `corr_o` updated this cycle |
| est_o | output | CODE_W+FRAC_W | Signed estimate with FRAC_W fractional bits |

## Verification
The hardest state to reach from the ports is the saturated estimate. A balanced exchange sequence keeps the correlation near zero, so random stimulus almost never drives the estimate to its bound. The bench therefore reads its own model of the delayed exchange value and picks the digit so that s·d is a known sign. It then applies large residues of a fixed sign, which drives the estimate into each bound in a few samples. Convergence is reached by modelling the stage as a small random input plus s·d·δ over a few thousand strobes. Every sample is also compared exactly against the bench model, and the final estimate is compared against −δ.

// File: rtl/capcal_pkg.sv
package capcal_pkg;

   localparam logic [1:0] DIG_ZERO = 2'b00;
   localparam logic [1:0] DIG_POS  = 2'b01;
   localparam logic [1:0] DIG_BAD  = 2'b10;
   localparam logic [1:0] DIG_NEG  = 2'b11;

   // feedback mask for a maximal-length Fibonacci LFSR of a given width
   function automatic logic [31:0] tap_mask(input int unsigned w);
      logic [31:0] m;
      case (w)
         8:       m = 32'h0000_00B8;
         16:      m = 32'h0000_B400;
         24:      m = 32'h00E1_0000;
         32:      m = 32'h8020_0003;
         default: m = 32'h0000_0000;
      endcase
      return m;
   endfunction

   // product of exchange sign (1 = +1) and an encoded digit, same encoding
   function automatic logic [1:0] sign_mul(input logic s_pos, input logic [1:0] dig);
      logic [1:0] r;
      if (dig == DIG_ZERO || dig == DIG_BAD) r = DIG_ZERO;
      else if (s_pos)                         r = dig;
      else                                    r = (dig == DIG_POS) ? DIG_NEG : DIG_POS;
      return r;
   endfunction

endpackage

// File: rtl/capcal_lfsr.sv
module capcal_lfsr #(
   parameter int unsigned W    = 16,
   parameter int unsigned SEED = 32'h0000_ACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic bit_o
);
   import capcal_pkg::*;

   localparam logic [31:0]  MASK32 = tap_mask(W);
   localparam logic [W-1:0] TAPS   = MASK32[W-1:0];
   localparam logic [W-1:0] SEED_V = W'(SEED);

   generate
      if (TAPS == '0) begin : g_bad_width
         $error("capcal_lfsr: width has no tap table entry");
      end
      if (SEED_V == '0) begin : g_bad_seed
         $error("capcal_lfsr: seed must be nonzero");
      end
   endgenerate

   logic [W-1:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= SEED_V;
      else if (adv) st_q <= {st_q[W-2:0], ^(st_q & TAPS)};
   end

   assign bit_o = st_q[0];

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(st_q));
   p_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != '0);
   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> st_q[W-1:1] == $past(st_q[W-2:0]));

endmodule

// File: rtl/capcal_align.sv
module capcal_align #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic cur_i,
   output logic used_o
);
   generate
      if (LAT < 1) begin : g_bad_lat
         $error("capcal_align: LAT must be at least 1");
      end
   endgenerate

   logic [LAT-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (adv) begin
         q[0] <= cur_i;
         for (int i = 1; i < int'(LAT); i++) q[i] <= q[i-1];
      end
   end

   assign used_o = q[LAT-1];

   p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(q));
   p_hist_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> q[0] == $past(cur_i));

endmodule

// File: rtl/capcal_est.sv
module capcal_est #(
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned FRAC_W  = 10,
   parameter int unsigned STEP_SH = 6,
   parameter int          EST_LIM = 65536
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               clr,
   input  logic                               vld,
   input  logic [1:0]                         sd,
   input  logic signed [CODE_W-1:0]           res,
   output logic signed [CODE_W:0]             corr_o,
   output logic                               corr_vld_o,
   output logic signed [CODE_W+FRAC_W-1:0]    est_o
);
   import capcal_pkg::*;

   localparam int unsigned EST_W = CODE_W + FRAC_W;
   localparam int unsigned ACC_W = EST_W + 2;
   localparam int unsigned SHL   = FRAC_W - STEP_SH;
   localparam logic signed [ACC_W-1:0] LIM_P = ACC_W'(EST_LIM);
   localparam logic signed [ACC_W-1:0] LIM_N = -LIM_P;

   generate
      if (STEP_SH > FRAC_W) begin : g_bad_step
         $error("capcal_est: STEP_SH must not exceed FRAC_W");
      end
      if (EST_LIM <= 0 || longint'(EST_LIM) > (longint'(1) <<< (EST_W - 2))) begin : g_bad_lim
         $error("capcal_est: EST_LIM out of range");
      end
   endgenerate

   logic signed [EST_W-1:0]  est_q;
   logic signed [CODE_W-1:0] est_int;
   logic signed [CODE_W:0]   est_int_x, res_x, ofs, corr_d, prod;
   logic signed [ACC_W-1:0]  prod_x, delta, est_x, raw, sat;

   always_comb begin
      est_int   = est_q[EST_W-1:FRAC_W];
      est_int_x = {est_int[CODE_W-1], est_int};
      res_x     = {res[CODE_W-1], res};
      case (sd)
         DIG_POS: ofs = est_int_x;
         DIG_NEG: ofs = -est_int_x;
         default: ofs = '0;
      endcase
      corr_d = res_x + ofs;
      case (sd)
         DIG_POS: prod = corr_d;
         DIG_NEG: prod = -corr_d;
         default: prod = '0;
      endcase
      prod_x = ACC_W'(prod);
      delta  = prod_x <<< SHL;
      est_x  = ACC_W'(est_q);
      raw    = est_x - delta;
      if (raw > LIM_P)      sat = LIM_P;
      else if (raw < LIM_N) sat = LIM_N;
      else                  sat = raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         est_q      <= '0;
         corr_o     <= '0;
         corr_vld_o <= 1'b0;
      end else begin
         corr_vld_o <= vld;
         if (vld) corr_o <= corr_d;
         if (clr)                          est_q <= '0;
         else if (vld && sd != DIG_ZERO)   est_q <= sat[EST_W-1:0];
      end
   end

   assign est_o = est_q;

   p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ACC_W'(est_q) <= LIM_P) && (ACC_W'(est_q) >= LIM_N));
   p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && sd == DIG_ZERO && !clr) |=> $stable(est_q));
   p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && sd == DIG_ZERO) |=> corr_o == {$past(res[CODE_W-1]), $past(res)});
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> est_q == '0);
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld && !clr) |=> ($stable(est_q) && $stable(corr_o)));
   p_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> corr_vld_o);
   p_novld_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> !corr_vld_o);

endmodule

// File: rtl/capcal_stage.sv
module capcal_stage #(
   parameter int unsigned CODE_W   = 12,
   parameter int unsigned FRAC_W   = 10,
   parameter int unsigned STEP_SH  = 6,
   parameter int          EST_LIM  = 65536,
   parameter int unsigned LFSR_W   = 16,
   parameter int unsigned SEED     = 32'h0000_ACE1,
   parameter int unsigned LAT      = 2,
   parameter bit          HALF_BIT = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              est_clr_i,
   input  logic                              smp_vld_i,
   input  logic [1:0]                        digit_i,
   input  logic signed [CODE_W-1:0]          res_i,
   output logic                              swap_o,
   output logic signed [CODE_W:0]            corr_o,
   output logic                              corr_vld_o,
   output logic signed [CODE_W+FRAC_W-1:0]   est_o
);
   import capcal_pkg::*;

   logic swap_cur, swap_used;
   logic [1:0] sd;

   capcal_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv(smp_vld_i), .bit_o(swap_cur));

   capcal_align #(.LAT(LAT)) u_align (
      .clk(clk), .rst_n(rst_n), .adv(smp_vld_i), .cur_i(swap_cur), .used_o(swap_used));

   assign sd     = sign_mul(swap_used, digit_i);
   assign swap_o = swap_cur;

   capcal_est #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .STEP_SH(STEP_SH), .EST_LIM(EST_LIM)) u_est (
      .clk(clk), .rst_n(rst_n), .clr(est_clr_i), .vld(smp_vld_i), .sd(sd), .res(res_i),
      .corr_o(corr_o), .corr_vld_o(corr_vld_o), .est_o(est_o));

   p_digit_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld_i |-> digit_i != DIG_BAD);

   generate
      if (!HALF_BIT) begin : g_one_bit
         p_onebit_digit_r4: assert property (@(posedge clk) disable iff (!rst_n)
            smp_vld_i |-> digit_i != DIG_ZERO);
      end
   endgenerate

endmodule

// File: tb/capcal_stage_test.sv
`timescale 1ns/1ps
module capcal_stage_test;
   localparam int CW = 12, FW = 10, SS = 6, LIM = 65536, LAT = 2;
   localparam int DELTA = 9;

   logic clk = 0, rst_n = 0, clr = 0, vld = 0;
   logic [1:0] dig = 2'b00;
   logic signed [CW-1:0] res = '0;
   logic swap;
   logic signed [CW:0] corr;
   logic cvld;
   logic signed [CW+FW-1:0] est;

   capcal_stage uut (.clk(clk), .rst_n(rst_n), .est_clr_i(clr), .smp_vld_i(vld),
      .digit_i(dig), .res_i(res), .swap_o(swap), .corr_o(corr), .corr_vld_o(cvld), .est_o(est));

   always #2 clk = ~clk;

   int total = 0, bad = 0;
   logic [15:0] m_st = 16'hACE1;
   logic [LAT-1:0] m_hist = '0;
   longint m_est = 0;

   function automatic int dval(input logic [1:0] d);
      return (d == 2'b01) ? 1 : (d == 2'b11) ? -1 : 0;
   endfunction

   function automatic logic [15:0] lfsr_nx(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic int used_s();
      return m_hist[LAT-1] ? 1 : -1;
   endfunction

   task automatic chk(input string tag, input longint got, input longint exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   task automatic sample(input logic [1:0] d, input int r, input bit c);
      int s, dv;
      longint ei, ce, raw;
      @(negedge clk);
      vld = 1; dig = d; res = CW'(r); clr = c;
      s = used_s(); dv = dval(d);
      ei = m_est >>> FW;
      ce = r + s * dv * ei;
      if (c) m_est = 0;
      else if (dv != 0) begin
         raw = m_est - longint'(s * dv) * ce * (longint'(1) <<< (FW - SS));
         m_est = (raw > LIM) ? LIM : (raw < -LIM) ? -LIM : raw;
      end
      m_hist = {m_hist[LAT-2:0], m_st[0]};
      m_st = lfsr_nx(m_st);
      @(posedge clk); #1;
      chk("R5 corrected code", corr, ce);
      chk("R5 valid", cvld, 1);
      chk("R6/R8/R9 estimate", est, m_est);
      chk("R2 swap", swap, m_st[0]);
   endtask

   task automatic idle(input int n);
      logic signed [CW:0] c0;
      @(negedge clk);
      vld = 0; clr = 0; c0 = corr;
      repeat (n) @(posedge clk);
      #1;
      chk("R10 swap hold", swap, m_st[0]);
      chk("R10 est hold", est, m_est);
      chk("R10 corr hold", corr, c0);
      chk("R5 no valid", cvld, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(1234));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 est", est, 0); chk("R1 valid", cvld, 0);
      chk("R1 corr", corr, 0); chk("R1 swap", swap, 1);
      @(negedge clk); rst_n = 1;
      // first LAT samples use -1 (R3)
      sample(2'b01, 100, 0);
      sample(2'b11, -50, 0);
      // random mixed digits and residues (R2 R3 R5 R6)
      for (int i = 0; i < 300; i++) begin
         int r; logic [1:0] d;
         r = int'($urandom_range(3000)) - 1500;
         case ($urandom_range(2)) 0: d = 2'b01; 1: d = 2'b11; default: d = 2'b00; endcase
         sample(d, r, 0);
      end
      // zero digit: no update, pass-through (R7)
      for (int i = 0; i < 5; i++) begin
         longint e0; e0 = m_est;
         sample(2'b00, 700 - i * 300, 0);
         chk("R7 est unchanged", est, e0);
      end
      idle(4);
      // saturation low then high (R8)
      for (int i = 0; i < 8; i++) sample(used_s() > 0 ? 2'b01 : 2'b11, 1900, 0);
      chk("R8 low bound", est, -LIM);
      for (int i = 0; i < 8; i++) sample(used_s() > 0 ? 2'b01 : 2'b11, -1900, 0);
      chk("R8 high bound", est, LIM);
      // clear has priority over the update (R9)
      sample(2'b01, 1000, 1);
      chk("R9 clear", est, 0);
      // convergence with stage mismatch (R11)
      for (int i = 0; i < 3000; i++) begin
         int v, dv; logic [1:0] d;
         v = int'($urandom_range(40)) - 20;
         d = $urandom_range(1) ? 2'b01 : 2'b11;
         dv = dval(d);
         sample(d, v + used_s() * dv * DELTA, 0);
      end
      total++;
      if ((est >>> FW) > -DELTA + 3 || (est >>> FW) < -DELTA - 3) begin
         bad++;
         $display("FAIL R11 converge got=%0d exp=%0d", est >>> FW, -DELTA);
      end
      idle(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule